// File: doc/BRIEF.md
# Close-Path Significand Subtractor with Leading-One Anticipation

This block handles the near-cancellation leg of a floating-point effective subtraction: the case where the two operand exponents are equal or one apart. It accepts two normalized significands, with the hidden bit as the MSB, together with their biased exponents. It aligns the operand with the smaller exponent by at most one place and subtracts the two magnitudes. The result is left-normalized in the same cycle, and the outputs are registered. The shift it reports is the amount by which the result exponent has to be reduced.

The operand order and the one-place alignment are guessed from the two low exponent bits alone, so the significand subtraction does not have to wait for a full exponent subtractor. The full exponent gap is computed alongside. When the gap turns out to be two or more, the block raises an abort so that a separate far-path unit can take the operation. Subtraction is done by adding the inverted subtrahend with a carry-in of one. A leading-one anticipation vector is built from the operand bits in parallel with the carry chain, and a priority count over that vector drives the normalizing shifter. One further single-place shift repairs the anticipation when it is one place high. When the exponents are equal and the second operand is the larger, the two's-complement difference is negated and a sign-flip flag is raised. Because at most one bit is shifted out during alignment, and that bit is kept in an extra low-order position, the result is exact and needs no rounding.

Top module: `close_path_sub`

## Requirements
- R1: `outValid` is high in the cycle after the one in which `inValid` was sampled high, and that cycle's outputs belong to the operand pair sampled then. When `inValid` is sampled low, `outValid` is low on the next cycle and all other outputs keep their previous values.
- R2: When the true exponent gap |aExp - bExp| is 2 or more, `farAbort` is 1 and `normSig`, `shiftAmt`, `zeroFlag` and `signFlip` are all 0. Otherwise `farAbort` is 0.
- R3: The working width is W = SIG_W+1. Each significand is extended with one zero LSB. When the exponents differ by one, the operand with the smaller exponent is used without that extra zero, which is a right shift by one. The difference magnitude `mag` is the exact absolute difference of the two aligned W-bit values, and no bit is lost.
- R4: For a non-zero, non-aborted result, `normSig` equals `mag` shifted left by `shiftAmt` within W bits, and bit W-1 of `normSig` is 1.
- R5: `shiftAmt` equals the number of leading zeros of `mag` in a W-bit field. This holds whether or not the anticipated leading-one position was one place too high.
- R6: When `mag` is zero (equal exponents and equal significands), `zeroFlag` is 1 and `normSig` and `shiftAmt` are 0. Otherwise `zeroFlag` is 0.
- R7: `signFlip` is 1 exactly when the B operand's aligned value exceeds A's, so that the result sign is opposite to A's. That is the case when bExp = aExp+1, or when the exponents are equal and bSig > aSig.
- R8: The speculation from the two low exponent bits never changes a result. Pairs whose low bits wrap, such as 4 against 3, and pairs whose gap is a multiple of four, such as 5 against 1, give the results that R2 to R7 require.
- R9: While `rstN` is low, and on the first output cycle after reset, `outValid`, `normSig`, `shiftAmt`, `zeroFlag`, `signFlip` and `farAbort` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand pair present this cycle |
| aExp | input | EXP_W | Biased exponent of operand A |
| aSig | input | SIG_W | Significand of A, hidden bit at MSB |
| bExp | input | EXP_W | Biased exponent of operand B |
| bSig | input | SIG_W | Significand of B, hidden bit at MSB |
| outValid | output | 1 | Registered result valid |
| normSig | output | SIG_W+1 | Normalized difference magnitude |
| shiftAmt | output | clog2(SIG_W+1) | Total left shift applied, equal to the exponent decrement |
| zeroFlag | output | 1 | Difference is exactly zero |
| signFlip | output | 1 | Result sign is the opposite of A's sign |
| farAbort | output | 1 | Exponent gap is too large for this path |

## Verification
The assertions assume that both significands arrive with their MSB set, because the normalization property depends on a difference whose alignment shift never makes the smaller operand larger. The stimulus therefore forces the hidden bit on every operand it applies, whether the operand is directed or random. It also keeps exponents far enough from the ends of their range that the gap in either direction never wraps. Random pairs are drawn with gaps of up to four either way. They are mixed with near-identical significands, so that deep cancellations and off-by-one anticipations occur often, and with idle cycles that exercise the hold behaviour.

// File: rtl/close_sub_pkg.sv
package close_sub_pkg;

  // Strobes from the exponent control to the significand datapath
  typedef struct packed {
    logic load;      // capture a new operand pair
    logic swap;      // B is the larger-exponent operand
    logic alignOne;  // smaller operand needs a one-place right shift
    logic abort;     // true gap exceeds one, far path owns the op
  } subCtl_t;

endpackage

// File: rtl/close_sub_ctrl.sv
module close_sub_ctrl
  import close_sub_pkg::*;
#(
  parameter int EXP_W = 8
) (
  input  logic             inValid,
  input  logic [EXP_W-1:0] aExp,
  input  logic [EXP_W-1:0] bExp,
  output subCtl_t          ctl
);

  localparam logic signed [EXP_W:0] GAP_HI = 1;
  localparam logic signed [EXP_W:0] GAP_LO = -1;

  logic [1:0]              lsbGap;
  logic signed [EXP_W:0]   trueGap;

  always_comb begin
    // Fast guess: modular gap of the two low exponent bits
    lsbGap       = aExp[1:0] - bExp[1:0];
    // Full gap, resolved alongside the significand subtraction
    trueGap      = $signed({1'b0, aExp}) - $signed({1'b0, bExp});
    ctl.load     = inValid;
    ctl.swap     = (lsbGap == 2'd3);
    ctl.alignOne = lsbGap[0];
    ctl.abort    = (trueGap > GAP_HI) || (trueGap < GAP_LO);
  end

endmodule

// File: rtl/close_sub_lop.sv
module close_sub_lop #(
  parameter int W = 25
) (
  input  logic [W-1:0] xOp,
  input  logic [W-1:0] yOp,
  output logic [W-1:0] posVec,
  output logic [W-1:0] negVec
);

  logic [W-1:0] bOp;
  logic [W-1:0] prop;
  logic [W-1:0] gen;
  logic [W-1:0] kill;

  assign bOp  = ~yOp;
  assign prop = xOp ^ bOp;
  assign gen  = xOp & bOp;
  assign kill = ~xOp & ~bOp;

  // posVec anticipates the leading one of xOp - yOp when it is non-negative,
  // negVec that of yOp - xOp (generate and kill roles exchanged).
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic propUp;
    logic killDn;
    logic genDn;
    if (i == W-1) begin : g_top
      assign propUp = 1'b1;
    end else begin : g_mid
      assign propUp = prop[i+1];
    end
    if (i == 0) begin : g_lsb
      assign killDn = 1'b0;
      assign genDn  = 1'b0;
    end else begin : g_up
      assign killDn = kill[i-1];
      assign genDn  = gen[i-1];
    end
    assign posVec[i] = (~propUp | gen[i])  & ~killDn;
    assign negVec[i] = (~propUp | kill[i]) & ~genDn;
  end

endmodule

// File: rtl/close_sub_dp.sv
module close_sub_dp
  import close_sub_pkg::*;
#(
  parameter int SIG_W = 24,
  parameter int W     = SIG_W + 1,
  parameter int SHW   = $clog2(W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  subCtl_t          ctl,
  input  logic [SIG_W-1:0] aSig,
  input  logic [SIG_W-1:0] bSig,
  output logic             outValid,
  output logic [W-1:0]     normSig,
  output logic [SHW-1:0]   shiftAmt,
  output logic             zeroFlag,
  output logic             signFlip,
  output logic             farAbort
);

  logic [SIG_W-1:0] bigSig;
  logic [SIG_W-1:0] smlSig;
  logic [W-1:0]     xOp;
  logic [W-1:0]     yOp;
  logic [W:0]       diffExt;
  logic             isNeg;
  logic [W-1:0]     mag;
  logic [W-1:0]     posVec;
  logic [W-1:0]     negVec;
  logic [W-1:0]     predVec;
  logic [SHW-1:0]   lead;
  logic             found;
  logic [W-1:0]     coarse;
  logic             fixUp;
  logic [W-1:0]     fineSig;
  logic [SHW-1:0]   totalShift;
  logic             magZero;

  // Operand order and one-place alignment from the speculative strobes
  always_comb begin
    bigSig = ctl.swap ? bSig : aSig;
    smlSig = ctl.swap ? aSig : bSig;
    xOp    = {bigSig, 1'b0};
    yOp    = ctl.alignOne ? {1'b0, smlSig} : {smlSig, 1'b0};
  end

  close_sub_lop #(.W(W)) u_lop (
    .xOp    (xOp),
    .yOp    (yOp),
    .posVec (posVec),
    .negVec (negVec)
  );

  always_comb begin
    // Inverted subtrahend plus forced carry-in
    diffExt = {1'b0, xOp} + {1'b0, ~yOp} + {{W{1'b0}}, 1'b1};
    isNeg   = ~diffExt[W];
    mag     = isNeg ? (~diffExt[W-1:0] + {{(W-1){1'b0}}, 1'b1}) : diffExt[W-1:0];
    magZero = ~|mag;
    predVec = isNeg ? negVec : posVec;

    // Priority count over the anticipation vector
    lead  = '0;
    found = 1'b0;
    for (int k = W-1; k >= 0; k--) begin
      if (!found && predVec[k]) begin
        found = 1'b1;
        lead  = SHW'(W-1-k);
      end
    end

    coarse     = mag << lead;
    fixUp      = ~coarse[W-1] & ~magZero;
    fineSig    = fixUp ? {coarse[W-2:0], 1'b0} : coarse;
    totalShift = lead + {{(SHW-1){1'b0}}, fixUp};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      normSig  <= '0;
      shiftAmt <= '0;
      zeroFlag <= 1'b0;
      signFlip <= 1'b0;
      farAbort <= 1'b0;
    end else begin
      outValid <= ctl.load;
      if (ctl.load) begin
        farAbort <= ctl.abort;
        if (ctl.abort) begin
          normSig  <= '0;
          shiftAmt <= '0;
          zeroFlag <= 1'b0;
          signFlip <= 1'b0;
        end else begin
          normSig  <= fineSig;
          shiftAmt <= magZero ? '0 : totalShift;
          zeroFlag <= magZero;
          signFlip <= ctl.swap ^ isNeg;
        end
      end
    end
  end

endmodule

// File: rtl/close_path_sub.sv
module close_path_sub
  import close_sub_pkg::*;
#(
  parameter  int SIG_W = 24,
  parameter  int EXP_W = 8,
  localparam int W     = SIG_W + 1,
  localparam int SHW   = $clog2(W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [EXP_W-1:0] aExp,
  input  logic [SIG_W-1:0] aSig,
  input  logic [EXP_W-1:0] bExp,
  input  logic [SIG_W-1:0] bSig,
  output logic             outValid,
  output logic [W-1:0]     normSig,
  output logic [SHW-1:0]   shiftAmt,
  output logic             zeroFlag,
  output logic             signFlip,
  output logic             farAbort
);

  subCtl_t ctl;

  close_sub_ctrl #(.EXP_W(EXP_W)) u_ctrl (
    .inValid (inValid),
    .aExp    (aExp),
    .bExp    (bExp),
    .ctl     (ctl)
  );

  close_sub_dp #(.SIG_W(SIG_W), .W(W), .SHW(SHW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .aSig     (aSig),
    .bSig     (bSig),
    .outValid (outValid),
    .normSig  (normSig),
    .shiftAmt (shiftAmt),
    .zeroFlag (zeroFlag),
    .signFlip (signFlip),
    .farAbort (farAbort)
  );

endmodule

// File: rtl/close_path_sub_chk.sv
module close_path_sub_chk #(
  parameter  int SIG_W = 24,
  parameter  int EXP_W = 8,
  localparam int W     = SIG_W + 1,
  localparam int SHW   = $clog2(W)
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [EXP_W-1:0] aExp,
  input logic [EXP_W-1:0] bExp,
  input logic             outValid,
  input logic [W-1:0]     normSig,
  input logic [SHW-1:0]   shiftAmt,
  input logic             zeroFlag,
  input logic             signFlip,
  input logic             farAbort
);

  int   gapInt;
  logic gapFar;

  always_comb begin
    gapInt = int'(aExp) - int'(bExp);
    gapFar = (gapInt > 1) || (gapInt < -1);
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(normSig) && $stable(shiftAmt) && $stable(farAbort)));

  // R2
  abort_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (farAbort == $past(gapFar)));

  // R2
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    farAbort |-> (normSig == '0 && shiftAmt == '0 && !zeroFlag && !signFlip));

  // R4
  normalized_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !farAbort && !zeroFlag) |-> normSig[W-1]);

  // R5
  shift_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftAmt <= SHW'(W-1));

  // R6
  zero_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroFlag |-> (normSig == '0 && shiftAmt == '0 && !signFlip));

endmodule

bind close_path_sub close_path_sub_chk #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .aExp     (aExp),
  .bExp     (bExp),
  .outValid (outValid),
  .normSig  (normSig),
  .shiftAmt (shiftAmt),
  .zeroFlag (zeroFlag),
  .signFlip (signFlip),
  .farAbort (farAbort)
);

// File: tb/sim_close_path_sub.sv
module sim_close_path_sub;

  localparam int CLK_PERIOD = 10;
  localparam int SIG_W      = 24;
  localparam int EXP_W      = 8;
  localparam int W          = SIG_W + 1;
  localparam int SHW        = $clog2(W);
  localparam longint MASK   = (64'sd1 <<< W) - 1;

  logic             clk = 1'b0;
  logic             rstN;
  logic             inValid;
  logic [EXP_W-1:0] aExp;
  logic [SIG_W-1:0] aSig;
  logic [EXP_W-1:0] bExp;
  logic [SIG_W-1:0] bSig;
  logic             outValid;
  logic [W-1:0]     normSig;
  logic [SHW-1:0]   shiftAmt;
  logic             zeroFlag;
  logic             signFlip;
  logic             farAbort;

  int  vecCount  = 0;
  int  missCount = 0;
  bit  finished  = 1'b0;

  // Reference state: the outputs expected after the next edge
  longint expValid = 0, expNorm = 0, expShift = 0, expZero = 0, expFlip = 0, expAbort = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  close_path_sub #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u0 (
    .clk (clk), .rstN (rstN), .inValid (inValid),
    .aExp (aExp), .aSig (aSig), .bExp (bExp), .bSig (bSig),
    .outValid (outValid), .normSig (normSig), .shiftAmt (shiftAmt),
    .zeroFlag (zeroFlag), .signFlip (signFlip), .farAbort (farAbort)
  );

  task automatic checkOne(input string req, input string ctx, input longint act, input longint exp);
    vecCount++;
    if (act != exp) begin
      missCount++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, ctx, act, exp);
    end
  endtask

  task automatic compareAll(input string ctx);
    checkOne("R1", ctx, longint'(outValid), expValid);
    checkOne("R2", ctx, longint'(farAbort), expAbort);
    checkOne("R4", ctx, longint'(normSig),  expNorm);
    checkOne("R5", ctx, longint'(shiftAmt), expShift);
    checkOne("R6", ctx, longint'(zeroFlag), expZero);
    checkOne("R7", ctx, longint'(signFlip), expFlip);
  endtask

  // Behavioural model of the requirements (R2..R7)
  task automatic model(input int ae, input longint as, input int be, input longint bs);
    int     gap;
    longint xa, xb, dif, mag;
    int     sh;
    gap = ae - be;
    expAbort = 0;
    if (gap > 1 || gap < -1) begin
      expAbort = 1; expNorm = 0; expShift = 0; expZero = 0; expFlip = 0;
    end else begin
      xa = as <<< 1;
      xb = bs <<< 1;
      if (gap == 1)  xb = bs;   // R3 smaller exponent shifted right by one
      if (gap == -1) xa = as;
      dif = xa - xb;
      expFlip = (dif < 0) ? 1 : 0;
      mag = (dif < 0) ? -dif : dif;
      expZero = (mag == 0) ? 1 : 0;
      sh = 0;
      if (mag != 0)
        while ((((mag <<< sh) >>> (W-1)) & 1) == 0) sh++;
      expShift = sh;
      expNorm = (mag <<< sh) & MASK;
    end
  endtask

  task automatic drive(input bit v, input int ae, input longint as, input int be, input longint bs,
                       input string ctx);
    inValid = v;
    aExp = EXP_W'(ae);
    aSig = SIG_W'(as);
    bExp = EXP_W'(be);
    bSig = SIG_W'(bs);
    expValid = v ? 1 : 0;
    if (v) model(ae, as, be, bs);
    @(negedge clk);
    compareAll(ctx);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    missCount++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    longint hid;
    hid = 64'sd1 <<< (SIG_W-1);
    rstN = 1'b0; inValid = 1'b0;
    aExp = '0; aSig = '0; bExp = '0; bSig = '0;
    repeat (3) @(negedge clk);
    compareAll("R9 reset");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R9 first cycle");

    // R6 identical operands
    drive(1, 100, hid | 24'h123456, 100, hid | 24'h123456, "R6 equal");
    // R7 equal exponents, B larger -> negation
    drive(1, 100, hid | 24'h000010, 100, hid | 24'h400000, "R7 negate");
    drive(1, 100, hid | 24'h400000, 100, hid | 24'h000010, "R7 positive");
    // R3 gap of one either way
    drive(1, 51, hid | 24'h0F0F0F, 50, hid | 24'h7ABCDE, "R3 gap+1");
    drive(1, 50, hid | 24'h0F0F0F, 51, hid | 24'h7ABCDE, "R3 gap-1");
    // R5 deepest cancellation: 1.000.. minus 0.111..1 shifted
    drive(1, 90, hid, 89, 64'hFFFFFF, "R5 deep cancel");
    drive(1, 90, hid | 1, 90, hid, "R5 one ulp");
    drive(1, 90, hid | 24'h400000, 90, hid | 24'h2AAAAA, "R5 fixup");
    // R2 aborts
    drive(1, 120, hid, 118, hid, "R2 gap 2");
    drive(1, 118, hid, 121, hid, "R2 gap -3");
    // R8 low-bit wrap and gaps that are multiples of four
    drive(1, 4, hid | 24'h00FFFF, 3, hid | 24'h7FFFFF, "R8 wrap 4v3");
    drive(1, 3, hid | 24'h00FFFF, 4, hid | 24'h7FFFFF, "R8 wrap 3v4");
    drive(1, 5, hid, 1, hid, "R8 gap 4");
    drive(1, 4, hid, 2, hid, "R8 gap 2 low bits");
    // R1 idle cycles hold outputs
    drive(0, 0, 0, 0, 0, "R1 idle");
    drive(0, 7, 5, 9, 3, "R1 idle junk");

    for (int n = 0; n < 3000; n++) begin
      int     base, gap, mode;
      longint sa, sb;
      base = int'($urandom_range(8, 240));
      gap  = int'($urandom_range(0, 8)) - 4;
      mode = int'($urandom_range(0, 3));
      sa   = longint'($urandom) & (hid - 1) | hid;
      case (mode)
        0:       sb = longint'($urandom) & (hid - 1) | hid;
        1:       sb = (sa ^ longint'($urandom_range(0, 255))) | hid;
        2:       sb = sa;
        default: sb = (sa ^ (longint'($urandom) & 64'h3FF0)) | hid;
      endcase
      if ($urandom_range(0, 9) == 0)
        drive(0, base, sa, base - gap, sb, "R1 random idle");
      else
        drive(1, base, sa, base - gap, sb, "R8 random");
    end

    finishRun();
  end

endmodule